// File: doc/BRIEF.md
# CPU Bus Ownership Sequencer

This block sits next to an 8-bit processor that shares its address and data buses through an active-low request/acknowledge handshake. On command from a host, it takes the buses away from the processor or hands them back. It also holds, releases or pulses the processor's reset line. The block keeps one of four states, each combining the reset condition of the processor with who owns the bus. Every multi-cycle action runs as a timed sequence. The block accepts a new command only while `ready` is high.

A Request issued while the processor is held in reset lets go of reset and asks for the bus in the same cycle. It then counts the cycles until the processor grants the bus, so the host can see how quickly the processor answers after leaving reset. A Step command gives the bus back for just long enough that the processor runs one machine cycle, then takes it again. Every wait for the acknowledge is bounded by a timeout. When a timeout expires, the block raises a one-cycle error flag and takes a fixed fallback transition. All intervals are parameters counted in clock cycles: `BUS_TO`, `RST_HOLD`, `RST_PULSE` and `START_DLY`.

The four states and their codes are RESET (0), RESET_OWNED (1), RUNNING (2) and RUNNING_OWNED (3).

The transitions are:
- Reset: any state goes to RESET.
- Request: RESET goes to RESET_OWNED, and RUNNING goes to RUNNING_OWNED.
- Release: RESET_OWNED goes to RESET, and RUNNING_OWNED goes to RUNNING.
- Run: RESET goes to RUNNING, and RESET_OWNED goes to RUNNING_OWNED.
- Restart: RUNNING and RUNNING_OWNED each keep their state.
- Step: RUNNING_OWNED keeps its state on success and falls back to RUNNING on timeout.

Top module: `bus_grab_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, the outputs hold these values: `state`=0, `cpu_reset_n`=0, `busreq_n`=1, `addr_oe`=0, `data_oe`=0, `ready`=1, `acq_cycles`=0 and `timeout_err`=0.
- R2: A command is taken at a clock edge only when `ready`=1, `cmd_valid`=1 and exactly one bit of `cmd` is set. The bit positions are: bit0 Reset, bit1 Request, bit2 Release, bit3 Run, bit4 Restart, bit5 Step. A taken command that starts a sequence drops `ready` in the next cycle. Any other `cmd` value is ignored.
- R3: Reset, from any state, first floats both buses and drives `cpu_reset_n` low. `busreq_n` stays unchanged for RST_HOLD cycles and then rises. The block then waits up to BUS_TO cycles for `busack_n`=1 and enters RESET. If that wait times out, it still enters RESET and pulses `timeout_err`.
- R4: Request in RESET sets `busreq_n`=0 and `cpu_reset_n`=1 in the cycle after the command is taken. When `busack_n` is sampled low, it sets `addr_oe`=1 and enters RESET_OWNED.
- R5: On a successful Request from RESET, `acq_cycles` is set to k. Here k is the index of the first clock edge after the accepting edge that samples `busack_n`=0, so k runs from 1 to BUS_TO. Other commands leave `acq_cycles` unchanged.
- R6: If Request in RESET sees no acknowledge within BUS_TO edges, it restores `cpu_reset_n`=0 and `busreq_n`=1, stays in RESET and pulses `timeout_err`.
- R7: Request in RUNNING either gains the bus (`addr_oe`=1, state RUNNING_OWNED) or times out after BUS_TO edges (`busreq_n`=1, state RUNNING, `timeout_err` pulse). An acknowledge sampled on the last allowed edge counts as success.
- R8: Release in RUNNING_OWNED floats the buses, raises `busreq_n` and enters RUNNING once `busack_n`=1. Release in RESET_OWNED runs the Reset sequence of R3 and ends in RESET.
- R9: Run in RESET keeps `ready` low for START_DLY cycles, then raises `cpu_reset_n` and enters RUNNING. Run in RESET_OWNED floats the buses, drives `cpu_reset_n` low for RST_PULSE cycles, then sets `addr_oe`=1 and enters RUNNING_OWNED.
- R10: Restart in RUNNING or RUNNING_OWNED drives `cpu_reset_n` low for RST_PULSE cycles and leaves the state and `addr_oe` unchanged. Restart in RESET or RESET_OWNED is ignored.
- R11: Step in RUNNING_OWNED goes through these stages:
  1. It floats the buses and raises `busreq_n`.
  2. It lowers `busreq_n` again on the first edge that samples `busack_n`=1.
  3. It sets `addr_oe`=1 only after `busack_n` is sampled low again.
  4. If the acknowledge does not return within BUS_TO edges, it raises `busreq_n`, enters RUNNING and pulses `timeout_err`.
- R12: A single-bit command that has no transition from the current state leaves `ready`, the state and all bus and reset outputs unchanged.
- R13: `timeout_err` is high for exactly one cycle per timeout. `ready` returns to 1 in the same cycle that the sequence's final state appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 6 | One-hot command: 0 Reset, 1 Request, 2 Release, 3 Run, 4 Restart, 5 Step |
| busack_n | input | 1 | Bus acknowledge from the processor, active low |
| ready | output | 1 | High when a command can be taken |
| state | output | 2 | Current state code (0..3) |
| busreq_n | output | 1 | Bus request to the processor, active low |
| cpu_reset_n | output | 1 | Processor reset, active low |
| addr_oe | output | 1 | Enable for driving the address bus |
| data_oe | output | 1 | Enable for driving the data bus |
| acq_cycles | output | 32 | Measured acknowledge latency of the last Request from reset |
| timeout_err | output | 1 | One-cycle pulse when an acknowledge wait times out |

## Verification
The two functions that can land on the same edge are the expiry of an acknowledge timeout and the arrival of the acknowledge itself. The bench provokes this by lowering `busack_n` so that it is first sampled on exactly the BUS_TO-th edge after the Request was taken. It does this both from RUNNING and from RESET. It judges the result by requiring success: the owned state, `addr_oe`=1, no `timeout_err` pulse and, from RESET, a latency of exactly BUS_TO. The mirror case holds `busack_n` high for one more edge and must yield the fallback with a single error pulse.

// File: rtl/bus_grab_pkg.sv
package bus_grab_pkg;

    typedef enum logic [1:0] {
        ST_RESET     = 2'd0,
        ST_RESET_OWN = 2'd1,
        ST_RUN       = 2'd2,
        ST_RUN_OWN   = 2'd3
    } own_state_e;

    localparam int CMD_W = 6;

    // Operation codes: bit index of the one-hot command plus one
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RESET   = 3'd1,
        OP_REQ     = 3'd2,
        OP_REL     = 3'd3,
        OP_RUN     = 3'd4,
        OP_RESTART = 3'd5,
        OP_STEP    = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_DROP_WAIT,
        PH_START,
        PH_ACK_WAIT,
        PH_PULSE,
        PH_STEP_DROP,
        PH_STEP_WAIT
    } phase_e;

endpackage

// File: rtl/bus_grab_cmd_dec.sv
module bus_grab_cmd_dec
    import bus_grab_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd,
    input  logic             ready,
    output op_e              op
);

    always_comb begin
        op = OP_NONE;
        if (cmd_valid && ready && $onehot(cmd)) begin
            for (int i = 0; i < CMD_W; i++) begin
                if (cmd[i]) begin
                    op = op_e'(3'(i + 1));
                end
            end
        end
    end

endmodule

// File: rtl/bus_grab_timer.sv
module bus_grab_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/bus_grab_lat_cnt.sv
module bus_grab_lat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAXC = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != MAXC) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/bus_grab_ctrl.sv
module bus_grab_ctrl
    import bus_grab_pkg::*;
#(
    parameter int BUS_TO    = 64,
    parameter int RST_HOLD  = 16,
    parameter int RST_PULSE = 4,
    parameter int START_DLY = 20,
    parameter int LAT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd,
    input  logic             busack_n,
    output logic             ready,
    output logic [1:0]       state,
    output logic             busreq_n,
    output logic             cpu_reset_n,
    output logic             addr_oe,
    output logic             data_oe,
    output logic [LAT_W-1:0] acq_cycles,
    output logic             timeout_err
);

    localparam int MAX_A = (BUS_TO > RST_HOLD) ? BUS_TO : RST_HOLD;
    localparam int MAX_B = (RST_PULSE > START_DLY) ? RST_PULSE : START_DLY;
    localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAXV + 1);

    localparam logic [TW-1:0] TO_LD    = TW'(BUS_TO - 1);
    localparam logic [TW-1:0] HOLD_LD  = TW'(RST_HOLD - 1);
    localparam logic [TW-1:0] PULSE_LD = TW'(RST_PULSE - 1);
    localparam logic [TW-1:0] START_LD = TW'(START_DLY - 1);

    own_state_e st_q, st_n, dest_q, dest_n;
    phase_e     ph_q, ph_n;
    op_e        op;

    logic breq_q, breq_d;
    logic crst_q, crst_d;
    logic aoe_q, aoe_d;
    logic doe_q, doe_d;
    logic err_q, err_d;
    logic [LAT_W-1:0] acq_q, acq_d;

    logic            tmr_load, tmr_zero;
    logic [TW-1:0]   tmr_val;
    logic            lat_clr, lat_inc;
    logic [LAT_W-1:0] lat_cnt;

    assign ready = (ph_q == PH_IDLE);

    bus_grab_cmd_dec i_dec (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .ready     (ready),
        .op        (op)
    );

    bus_grab_timer #(.W(TW)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    bus_grab_lat_cnt #(.W(LAT_W)) i_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lat_clr),
        .inc   (lat_inc),
        .count (lat_cnt)
    );

    // Next-state, sequencing and output logic
    always_comb begin
        st_n     = st_q;
        ph_n     = ph_q;
        dest_n   = dest_q;
        breq_d   = breq_q;
        crst_d   = crst_q;
        aoe_d    = aoe_q;
        doe_d    = doe_q;
        err_d    = 1'b0;
        acq_d    = acq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        lat_clr  = 1'b0;
        lat_inc  = 1'b0;

        unique case (ph_q)
            PH_IDLE: begin
                case (op)
                    OP_RESET: begin
                        aoe_d    = 1'b0;
                        doe_d    = 1'b0;
                        crst_d   = 1'b0;
                        dest_n   = ST_RESET;
                        ph_n     = PH_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = HOLD_LD;
                    end
                    OP_REQ: begin
                        if (st_q == ST_RESET || st_q == ST_RUN) begin
                            breq_d   = 1'b0;
                            crst_d   = 1'b1;
                            ph_n     = PH_ACK_WAIT;
                            tmr_load = 1'b1;
                            tmr_val  = TO_LD;
                            lat_clr  = 1'b1;
                        end
                    end
                    OP_REL: begin
                        if (st_q == ST_RESET_OWN) begin
                            aoe_d    = 1'b0;
                            doe_d    = 1'b0;
                            crst_d   = 1'b0;
                            dest_n   = ST_RESET;
                            ph_n     = PH_HOLD;
                            tmr_load = 1'b1;
                            tmr_val  = HOLD_LD;
                        end else if (st_q == ST_RUN_OWN) begin
                            aoe_d    = 1'b0;
                            doe_d    = 1'b0;
                            breq_d   = 1'b1;
                            dest_n   = ST_RUN;
                            ph_n     = PH_DROP_WAIT;
                            tmr_load = 1'b1;
                            tmr_val  = TO_LD;
                        end
                    end
                    OP_RUN: begin
                        if (st_q == ST_RESET) begin
                            ph_n     = PH_START;
                            tmr_load = 1'b1;
                            tmr_val  = START_LD;
                        end else if (st_q == ST_RESET_OWN) begin
                            aoe_d    = 1'b0;
                            doe_d    = 1'b0;
                            crst_d   = 1'b0;
                            dest_n   = ST_RUN_OWN;
                            ph_n     = PH_PULSE;
                            tmr_load = 1'b1;
                            tmr_val  = PULSE_LD;
                        end
                    end
                    OP_RESTART: begin
                        if (st_q == ST_RUN || st_q == ST_RUN_OWN) begin
                            crst_d   = 1'b0;
                            dest_n   = st_q;
                            ph_n     = PH_PULSE;
                            tmr_load = 1'b1;
                            tmr_val  = PULSE_LD;
                        end
                    end
                    OP_STEP: begin
                        if (st_q == ST_RUN_OWN) begin
                            aoe_d    = 1'b0;
                            doe_d    = 1'b0;
                            breq_d   = 1'b1;
                            ph_n     = PH_STEP_DROP;
                            tmr_load = 1'b1;
                            tmr_val  = TO_LD;
                        end
                    end
                    default: ;
                endcase
            end

            PH_HOLD: begin
                if (tmr_zero) begin
                    breq_d   = 1'b1;
                    ph_n     = PH_DROP_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TO_LD;
                end
            end

            PH_DROP_WAIT: begin
                if (busack_n) begin
                    st_n = dest_q;
                    ph_n = PH_IDLE;
                end else if (tmr_zero) begin
                    err_d = 1'b1;
                    st_n  = dest_q;
                    ph_n  = PH_IDLE;
                end
            end

            PH_START: begin
                if (tmr_zero) begin
                    crst_d = 1'b1;
                    st_n   = ST_RUN;
                    ph_n   = PH_IDLE;
                end
            end

            PH_ACK_WAIT: begin
                if (!busack_n) begin
                    aoe_d = 1'b1;
                    ph_n  = PH_IDLE;
                    if (st_q == ST_RESET) begin
                        st_n  = ST_RESET_OWN;
                        acq_d = lat_cnt + 1'b1;
                    end else begin
                        st_n  = ST_RUN_OWN;
                    end
                end else if (tmr_zero) begin
                    err_d  = 1'b1;
                    breq_d = 1'b1;
                    ph_n   = PH_IDLE;
                    if (st_q == ST_RESET) begin
                        crst_d = 1'b0;
                    end
                end else begin
                    lat_inc = 1'b1;
                end
            end

            PH_PULSE: begin
                if (tmr_zero) begin
                    crst_d = 1'b1;
                    st_n   = dest_q;
                    ph_n   = PH_IDLE;
                    if (dest_q == ST_RUN_OWN) begin
                        aoe_d = 1'b1;
                    end
                end
            end

            PH_STEP_DROP: begin
                if (busack_n) begin
                    breq_d   = 1'b0;
                    ph_n     = PH_STEP_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TO_LD;
                end else if (tmr_zero) begin
                    err_d    = 1'b1;
                    breq_d   = 1'b0;
                    ph_n     = PH_STEP_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TO_LD;
                end
            end

            PH_STEP_WAIT: begin
                if (!busack_n) begin
                    aoe_d = 1'b1;
                    ph_n  = PH_IDLE;
                end else if (tmr_zero) begin
                    err_d  = 1'b1;
                    breq_d = 1'b1;
                    st_n   = ST_RUN;
                    ph_n   = PH_IDLE;
                end
            end

            default: ph_n = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RESET;
            dest_q <= ST_RESET;
            ph_q   <= PH_IDLE;
        end else begin
            st_q   <= st_n;
            dest_q <= dest_n;
            ph_q   <= ph_n;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            breq_q <= 1'b1;
            crst_q <= 1'b0;
            aoe_q  <= 1'b0;
            doe_q  <= 1'b0;
            err_q  <= 1'b0;
            acq_q  <= '0;
        end else begin
            breq_q <= breq_d;
            crst_q <= crst_d;
            aoe_q  <= aoe_d;
            doe_q  <= doe_d;
            err_q  <= err_d;
            acq_q  <= acq_d;
        end
    end

    assign state       = st_q;
    assign busreq_n    = breq_q;
    assign cpu_reset_n = crst_q;
    assign addr_oe     = aoe_q;
    assign data_oe     = doe_q;
    assign acq_cycles  = acq_q;
    assign timeout_err = err_q;

endmodule

// File: rtl/bus_grab_chk.sv
module bus_grab_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       cmd_valid,
    input logic [1:0] state,
    input logic       busreq_n,
    input logic       cpu_reset_n,
    input logic       addr_oe,
    input logic       timeout_err
);

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cmd_valid) |=> ($stable(state) && $stable(cpu_reset_n) && $stable(busreq_n)));

    p_reset_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && state == 2'd0) |-> (!cpu_reset_n && busreq_n && !addr_oe));

    p_reset_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && state == 2'd1) |-> (cpu_reset_n && !busreq_n && addr_oe));

    p_running_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && state == 2'd2) |-> (cpu_reset_n && busreq_n && !addr_oe));

    p_running_owned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && state == 2'd3) |-> (!busreq_n && addr_oe));

    p_addr_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> !busreq_n);

    p_err_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    p_err_with_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (ready || !busreq_n));

endmodule

bind bus_grab_ctrl bus_grab_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .cmd_valid   (cmd_valid),
    .state       (state),
    .busreq_n    (busreq_n),
    .cpu_reset_n (cpu_reset_n),
    .addr_oe     (addr_oe),
    .timeout_err (timeout_err)
);

// File: tb/test_bus_grab_ctrl.sv
`timescale 1ns/1ps
module test_bus_grab_ctrl;

    localparam int TO    = 8;
    localparam int HOLD  = 3;
    localparam int PULSE = 2;
    localparam int SDLY  = 4;

    localparam logic [5:0] C_RESET   = 6'b000001;
    localparam logic [5:0] C_REQ     = 6'b000010;
    localparam logic [5:0] C_REL     = 6'b000100;
    localparam logic [5:0] C_RUN     = 6'b001000;
    localparam logic [5:0] C_RESTART = 6'b010000;
    localparam logic [5:0] C_STEP    = 6'b100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd = '0;
    logic        busack_n = 1'b1;
    logic        ready, busreq_n, cpu_reset_n, addr_oe, data_oe, timeout_err;
    logic [1:0]  state;
    logic [31:0] acq_cycles;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_grab_ctrl #(
        .BUS_TO(TO), .RST_HOLD(HOLD), .RST_PULSE(PULSE), .START_DLY(SDLY)
    ) i_bus_grab_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .busack_n(busack_n), .ready(ready), .state(state), .busreq_n(busreq_n),
        .cpu_reset_n(cpu_reset_n), .addr_oe(addr_oe), .data_oe(data_oe),
        .acq_cycles(acq_cycles), .timeout_err(timeout_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [5:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd = '0;
    endtask

    // Counts busy cycles and reset-low cycles until ready returns
    task automatic wait_idle(input bit follow, output int busy, output int rlow);
        busy = 0;
        rlow = 0;
        for (int i = 0; i < 200; i++) begin
            if (ready) break;
            busy++;
            if (!cpu_reset_n) rlow++;
            if (follow && busreq_n) busack_n = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state;
        chk("R1", "state", state, 0);
        chk("R1", "cpu_reset_n", cpu_reset_n, 0);
        chk("R1", "busreq_n", busreq_n, 1);
        chk("R1", "addr_oe", addr_oe, 0);
        chk("R1", "data_oe", data_oe, 0);
        chk("R1", "ready", ready, 1);
        chk("R1", "acq_cycles", acq_cycles, 0);
        chk("R1", "timeout_err", timeout_err, 0);
    endtask

    task automatic t_ignored_in_reset;
        logic [5:0] list [5] = '{C_REL, C_RESTART, C_STEP, 6'b000011, 6'b000000};
        for (int i = 0; i < 5; i++) begin
            send(list[i]);
            chk("R12", "ready after ignored cmd", ready, 1);
            chk("R2", "state after ignored cmd", state, 0);
            chk("R10", "cpu_reset_n after ignored cmd", cpu_reset_n, 0);
            chk("R12", "busreq_n after ignored cmd", busreq_n, 1);
        end
    endtask

    task automatic t_req_reset_timeout;
        send(C_REQ);
        chk("R4", "busreq_n asserted", busreq_n, 0);
        chk("R4", "reset released", cpu_reset_n, 1);
        chk("R2", "ready drops", ready, 0);
        repeat (TO - 1) @(negedge clk);
        chk("R6", "no early timeout", timeout_err, 0);
        @(negedge clk);
        chk("R6", "timeout flag", timeout_err, 1);
        chk("R6", "state", state, 0);
        chk("R6", "reset reasserted", cpu_reset_n, 0);
        chk("R6", "busreq_n", busreq_n, 1);
        chk("R13", "ready with fallback", ready, 1);
        @(negedge clk);
        chk("R13", "flag one cycle", timeout_err, 0);
    endtask

    task automatic t_req_reset_ok(input int k);
        send(C_REQ);
        repeat (k - 1) @(negedge clk);
        chk("R4", "still waiting", addr_oe, 0);
        busack_n = 1'b0;
        @(negedge clk);
        chk("R4", "state owned", state, 1);
        chk("R4", "addr_oe", addr_oe, 1);
        chk("R4", "cpu_reset_n", cpu_reset_n, 1);
        chk("R5", "latency", acq_cycles, k);
        chk("R5", "no timeout at limit", timeout_err, 0);
        chk("R13", "ready", ready, 1);
    endtask

    task automatic t_restart_ignored_own;
        send(C_RESTART);
        chk("R10", "ready stays", ready, 1);
        chk("R10", "reset not pulsed", cpu_reset_n, 1);
        chk("R10", "state", state, 1);
    endtask

    task automatic t_run_from_own;
        int busy, rlow;
        send(C_RUN);
        chk("R9", "buses floated", addr_oe, 0);
        wait_idle(1'b0, busy, rlow);
        chk("R9", "pulse width", rlow, PULSE);
        chk("R9", "state", state, 3);
        chk("R9", "addr_oe back", addr_oe, 1);
        chk("R9", "reset released", cpu_reset_n, 1);
    endtask

    task automatic t_step_ok;
        send(C_STEP);
        chk("R11", "busreq dropped", busreq_n, 1);
        chk("R11", "addr floated", addr_oe, 0);
        chk("R11", "data floated", data_oe, 0);
        busack_n = 1'b1;
        @(negedge clk);
        chk("R11", "busreq reasserted at once", busreq_n, 0);
        chk("R11", "addr waits for ack", addr_oe, 0);
        busack_n = 1'b0;
        @(negedge clk);
        chk("R11", "addr driven", addr_oe, 1);
        chk("R11", "state", state, 3);
        chk("R11", "ready", ready, 1);
    endtask

    task automatic t_restart_run_own;
        int busy, rlow;
        send(C_RESTART);
        chk("R10", "addr kept", addr_oe, 1);
        wait_idle(1'b0, busy, rlow);
        chk("R10", "pulse width", rlow, PULSE);
        chk("R10", "state kept", state, 3);
        chk("R10", "addr_oe kept", addr_oe, 1);
    endtask

    task automatic t_release_run_own;
        send(C_REL);
        chk("R8", "busreq_n", busreq_n, 1);
        chk("R8", "addr floated", addr_oe, 0);
        busack_n = 1'b1;
        @(negedge clk);
        chk("R8", "state running", state, 2);
        chk("R8", "ready", ready, 1);
    endtask

    task automatic t_req_run_timeout;
        send(C_REQ);
        chk("R7", "busreq_n", busreq_n, 0);
        repeat (TO - 1) @(negedge clk);
        chk("R7", "no early timeout", timeout_err, 0);
        @(negedge clk);
        chk("R7", "timeout", timeout_err, 1);
        chk("R7", "state", state, 2);
        chk("R7", "busreq_n", busreq_n, 1);
    endtask

    task automatic t_req_run_ok(input int k);
        send(C_REQ);
        repeat (k - 1) @(negedge clk);
        busack_n = 1'b0;
        @(negedge clk);
        chk("R7", "state", state, 3);
        chk("R7", "addr_oe", addr_oe, 1);
        chk("R7", "no timeout", timeout_err, 0);
        chk("R5", "latency untouched", acq_cycles, 3);
    endtask

    task automatic t_step_timeout;
        send(C_STEP);
        busack_n = 1'b1;
        @(negedge clk);
        chk("R11", "busreq reasserted", busreq_n, 0);
        repeat (TO - 1) @(negedge clk);
        chk("R11", "still waiting", ready, 0);
        @(negedge clk);
        chk("R11", "timeout", timeout_err, 1);
        chk("R11", "state fallback", state, 2);
        chk("R11", "busreq_n", busreq_n, 1);
        chk("R11", "addr_oe", addr_oe, 0);
    endtask

    task automatic t_reset_stuck;
        int hold = 0;
        send(C_RESET);
        chk("R3", "addr floated", addr_oe, 0);
        for (int i = 0; i < 100; i++) begin
            if (ready) break;
            if (!cpu_reset_n && !busreq_n) hold++;
            @(negedge clk);
        end
        chk("R3", "hold before busreq release", hold, HOLD);
        chk("R3", "timeout flag", timeout_err, 1);
        chk("R3", "state", state, 0);
        chk("R3", "busreq_n", busreq_n, 1);
        busack_n = 1'b1;
    endtask

    task automatic t_run_from_reset;
        int busy, rlow;
        send(C_RUN);
        wait_idle(1'b0, busy, rlow);
        chk("R9", "startup delay", busy, SDLY);
        chk("R9", "state", state, 2);
        chk("R9", "reset released", cpu_reset_n, 1);
    endtask

    task automatic t_reset_from_run;
        int busy, rlow;
        send(C_RESET);
        wait_idle(1'b1, busy, rlow);
        chk("R3", "busy cycles", busy, HOLD + 1);
        chk("R3", "no timeout", timeout_err, 0);
        chk("R3", "state", state, 0);
        chk("R3", "cpu_reset_n", cpu_reset_n, 0);
    endtask

    task automatic t_release_reset_own;
        int hold = 0;
        send(C_REL);
        chk("R8", "reset asserted", cpu_reset_n, 0);
        for (int i = 0; i < 100; i++) begin
            if (ready) break;
            if (!busreq_n) hold++;
            if (busreq_n) busack_n = 1'b1;
            @(negedge clk);
        end
        chk("R8", "hold", hold, HOLD);
        chk("R8", "state", state, 0);
        chk("R8", "busreq_n", busreq_n, 1);
        chk("R8", "addr_oe", addr_oe, 0);
        chk("R8", "no timeout", timeout_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ignored_in_reset();
        t_req_reset_timeout();
        t_req_reset_ok(3);
        t_restart_ignored_own();
        t_run_from_own();
        t_step_ok();
        t_restart_run_own();
        t_release_run_own();
        t_req_run_timeout();
        t_req_run_ok(TO);
        t_step_timeout();
        t_req_run_ok(1);
        t_reset_stuck();
        t_run_from_reset();
        t_reset_from_run();
        t_req_reset_ok(TO);
        t_release_reset_own();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule